// File: doc/BRIEF.md
# Ten-bit two-stage serializer

This block turns a stream of 10-bit parallel words into a single serial bit stream on one fast bit clock. A word is offered with a one-cycle load strobe and waits in a one-word holding buffer. At each word boundary the word is cut into an upper and a lower 5-bit half. The two halves are sent one after the other, upper half first, over two consecutive groups of five bit slots.

Each half sits in a lane staging register. That register changes only at a group boundary, so every lane holds still for the whole time it can be picked. A rotating one-hot phase ring with five positions chooses one lane per bit clock, and the chosen bit is registered onto the serial output. A marker output flags the first serial bit of every word. A strobe that arrives while the buffer is still occupied is refused and reported with a one-cycle overrun pulse. When no word is waiting, the output sends zeros for that word period and raises no marker.

In use, a producer loads a word whenever it sees the marker, which keeps the line busy with no gaps. At 600 MHz word rate this gives 6 Gb/s, with the phase ring stepping at the bit rate.

Top module: `tenbit_serializer`

## Requirements
- R1: During and right after reset, `ser_out`, `word_mark` and `load_overrun` are all 0.
- R2: Each word is sent most significant bit first: `word_in[9]` is the first serial bit and `word_in[0]` the tenth. The upper half `word_in[9:5]` is sent before the lower half `word_in[4:0]`.
- R3: `word_mark` is 1 during exactly the bit time of the first serial bit of each word, and 0 in the nine bit times that follow.
- R4: A word loaded while the previous word is being sent follows it with no gap, so consecutive markers are exactly 10 bit clocks apart.
- R5: A strobe is accepted if the holding buffer is empty, or if the buffer is being drained in that same cycle. An accepted word is sent whole, and no overrun is reported for it.
- R6: A strobe that arrives while the buffer is full and not being drained raises `load_overrun` for exactly one cycle, on the next clock. The word is discarded and the serial stream does not change.
- R7: A lane staging register changes only at a group boundary, so its value is constant over all five bit slots of its group.
- R8: The phase ring always holds exactly one set bit and steps one position per clock. The half selector toggles only when the ring leaves its last slot.
- R9: A word loaded while the serializer is idle has its first bit, with the marker, on `ser_out` no more than 12 bit clocks after the edge that samples the strobe.
- R10: In a word period with no word to send, `ser_out` stays 0 and `word_mark` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the ring steps one slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| word_load | input | 1 | One-cycle strobe that offers `word_in` |
| word_in | input | WORD_W | Parallel word; bit WORD_W-1 is sent first |
| ser_out | output | 1 | Registered serial bit |
| word_mark | output | 1 | High during the first serial bit of each word |
| load_overrun | output | 1 | One-cycle pulse when a strobe was refused |

## Verification
The bench rebuilds words from the serial stream, using the marker to find each word start. It then compares the rebuilt words with what was loaded.

Alternating K28.5 words of both disparities go out back to back. This exposes a swapped half order or a reversed bit order, because either one scrambles the five-ones and five-zeros runs. It also exposes a lost or repeated group, which would break the 10-cycle marker spacing.

Two strobe timings get their own tests:
- A second strobe one cycle after an accepted one must give a single overrun pulse and leave the stream unchanged. A design that overwrote the buffer would send the wrong word.
- A strobe landing on the very edge where the buffer drains must be accepted. A design that tested only the full flag would refuse it and leave a gap.

Idle periods must stay at zero with no marker. A design that re-sent stale lane data would show stray ones there.

// File: rtl/tws_pkg.sv
package tws_pkg;

  // Which half of the current word the lane stage is presenting.
  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;

endpackage

// File: rtl/slot_ring.sv
module slot_ring
  import tws_pkg::*;
#(
  parameter int LANES = 5
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LANES-1:0] slot_oh,
  output logic             group_end,
  output half_e            half_q
);

  localparam int LAST = LANES - 1;

  // One-hot phase ring: slot 0 after reset, one step per bit clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_oh <= {{(LANES-1){1'b0}}, 1'b1};
    end else begin
      slot_oh <= {slot_oh[LANES-2:0], slot_oh[LAST]};
    end
  end

  assign group_end = slot_oh[LAST];

  // Half selector runs at half the group rate. It resets to the lower
  // half, so the first group boundary after reset is a word boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= HALF_LOWER;
    end else if (group_end) begin
      half_q <= (half_q == HALF_UPPER) ? HALF_LOWER : HALF_UPPER;
    end
  end

  // R8: exactly one phase is active
  p_ring_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_oh) == 1);

  // R8: after the last slot the ring is back at slot 0
  p_ring_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    slot_oh[LAST] |=> slot_oh[0]);

  // R8: the half selector only moves at a group boundary
  p_half_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (half_q != $past(half_q)) |-> $past(slot_oh[LAST]));

endmodule

// File: rtl/word_intake.sv
module word_intake #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              take,
  output logic [WORD_W-1:0] buf_q,
  output logic              buf_full,
  output logic              overrun_q
);

  logic accept;
  logic refuse;

  // A strobe gets in if the slot is free, or is being emptied this cycle.
  assign accept = word_load && (!buf_full || take);
  assign refuse = word_load && buf_full && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q     <= '0;
      buf_full  <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      overrun_q <= refuse;
      if (accept) begin
        buf_q    <= word_in;
        buf_full <= 1'b1;
      end else if (take) begin
        buf_full <= 1'b0;
      end
    end
  end

  // R6: a refused strobe leaves the held word untouched
  p_refuse_keeps_word_r6: assert property (@(posedge clk) disable iff (rst)
    (word_load && buf_full && !take) |=> (buf_full && buf_q == $past(buf_q)));

  // R6: overrun is a single-cycle pulse per refused strobe
  p_overrun_cause_r6: assert property (@(posedge clk) disable iff (rst)
    overrun_q |-> ($past(word_load) && $past(buf_full)));

  // R5: a strobe on a draining edge is taken in
  p_accept_on_drain_r5: assert property (@(posedge clk) disable iff (rst)
    (word_load && take) |=> (buf_full && !overrun_q));

endmodule

// File: rtl/lane_stager.sv
module lane_stager
  import tws_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int LANES  = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              group_end,
  input  half_e             half_q,
  input  logic [WORD_W-1:0] buf_q,
  input  logic              buf_full,
  output logic              take,
  output logic [LANES-1:0]  stage_q,
  output logic              stage_valid,
  output logic              stage_first
);

  // A word boundary is the end of a lower-half group.
  assign take = group_end && (half_q == HALF_LOWER);

  logic [LANES-1:0] lower_hold;
  logic             lower_valid;

  // Per-lane retiming: each lane loads only at a group boundary, so it is
  // steady through every slot that may select it.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[l]    <= 1'b0;
        lower_hold[l] <= 1'b0;
      end else if (take) begin
        stage_q[l]    <= buf_full & buf_q[LANES + l];
        lower_hold[l] <= buf_full & buf_q[l];
      end else if (group_end) begin
        stage_q[l]    <= lower_hold[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_valid <= 1'b0;
      stage_first <= 1'b0;
      lower_valid <= 1'b0;
    end else if (take) begin
      stage_valid <= buf_full;
      stage_first <= buf_full;
      lower_valid <= buf_full;
    end else if (group_end) begin
      stage_valid <= lower_valid;
      stage_first <= 1'b0;
    end
  end

  // R7: lanes hold still inside a group
  p_lanes_steady_r7: assert property (@(posedge clk) disable iff (rst)
    !group_end |=> $stable(stage_q));

  // R10: an empty stage carries no ones
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !stage_valid |-> (stage_q == '0));

endmodule

// File: rtl/bit_picker.sv
module bit_picker #(
  parameter int LANES = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] slot_oh,
  input  logic [LANES-1:0] stage_q,
  input  logic             stage_valid,
  input  logic             stage_first,
  output logic             ser_out,
  output logic             word_mark
);

  localparam int LAST = LANES - 1;

  // Slot k selects lane LAST-k, so the top lane goes out first.
  logic [LANES-1:0] hit;
  logic             pick;

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    assign hit[k] = slot_oh[k] & stage_q[LAST - k];
  end

  assign pick = |hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out   <= 1'b0;
      word_mark <= 1'b0;
    end else begin
      ser_out   <= pick;
      word_mark <= stage_first & slot_oh[0];
    end
  end

  // R3: the marker only follows slot 0 of a word's first group
  p_mark_slot0_r3: assert property (@(posedge clk) disable iff (rst)
    word_mark |-> ($past(slot_oh[0]) && $past(stage_valid)));

  // R3: the marker never lasts into the second bit
  p_mark_single_r3: assert property (@(posedge clk) disable iff (rst)
    word_mark |=> !word_mark);

endmodule

// File: rtl/tenbit_serializer.sv
module tenbit_serializer
  import tws_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_load,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_out,
  output logic              word_mark,
  output logic              load_overrun
);

  localparam int LANES = WORD_W / 2;

  logic [LANES-1:0]  slot_oh;
  logic              group_end;
  half_e             half_q;
  logic              take;
  logic [WORD_W-1:0] buf_q;
  logic              buf_full;
  logic [LANES-1:0]  stage_q;
  logic              stage_valid;
  logic              stage_first;

  slot_ring #(.LANES(LANES)) i_ring (
    .clk       (clk),
    .rst       (rst),
    .slot_oh   (slot_oh),
    .group_end (group_end),
    .half_q    (half_q)
  );

  word_intake #(.WORD_W(WORD_W)) i_intake (
    .clk       (clk),
    .rst       (rst),
    .word_load (word_load),
    .word_in   (word_in),
    .take      (take),
    .buf_q     (buf_q),
    .buf_full  (buf_full),
    .overrun_q (load_overrun)
  );

  lane_stager #(.WORD_W(WORD_W), .LANES(LANES)) i_stage (
    .clk         (clk),
    .rst         (rst),
    .group_end   (group_end),
    .half_q      (half_q),
    .buf_q       (buf_q),
    .buf_full    (buf_full),
    .take        (take),
    .stage_q     (stage_q),
    .stage_valid (stage_valid),
    .stage_first (stage_first)
  );

  bit_picker #(.LANES(LANES)) i_pick (
    .clk         (clk),
    .rst         (rst),
    .slot_oh     (slot_oh),
    .stage_q     (stage_q),
    .stage_valid (stage_valid),
    .stage_first (stage_first),
    .ser_out     (ser_out),
    .word_mark   (word_mark)
  );

  // R1: outputs are quiet in the first cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!ser_out && !word_mark && !load_overrun));

endmodule

// File: tb/test_tenbit_serializer.sv
module test_tenbit_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int MAXW = 64;
  localparam int WATCHDOG = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         word_load = 1'b0;
  logic [W-1:0] word_in = '0;
  logic         ser_out;
  logic         word_mark;
  logic         load_overrun;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Deserializer state, filled by the monitor.
  logic [W-1:0] rx_w [MAXW];
  int           mark_cyc [MAXW];
  int           rx_cnt = 0;
  int           mark_cnt = 0;
  int           bitn = W;
  logic [W-1:0] cur = '0;

  tenbit_serializer #(.WORD_W(W)) i_tenbit_serializer (
    .clk          (clk),
    .rst          (rst),
    .word_load    (word_load),
    .word_in      (word_in),
    .ser_out      (ser_out),
    .word_mark    (word_mark),
    .load_overrun (load_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: rebuild words from the serial line, starting at each marker.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      bitn = W;
    end else begin
      if (word_mark) begin
        bitn = 0;
        cur = '0;
        if (mark_cnt < MAXW) mark_cyc[mark_cnt] = cyc;
        mark_cnt++;
      end
      if (bitn < W) begin
        cur = {cur[W-2:0], ser_out};
        bitn++;
        if (bitn == W) begin
          if (rx_cnt < MAXW) rx_w[rx_cnt] = cur;
          rx_cnt++;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive a strobe at the current negedge; release it at the next one.
  task automatic pulse_load(input logic [W-1:0] w);
    word_load = 1'b1;
    word_in   = w;
    @(negedge clk);
    word_load = 1'b0;
  endtask

  task automatic wait_mark(output int waited);
    waited = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      waited++;
      if (word_mark) return;
    end
    waited = -1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    int ones, marks;
    rst = 1'b1;
    idle(3);
    chk("R1", ser_out, 0, "ser_out in reset");
    chk("R1", word_mark, 0, "word_mark in reset");
    chk("R1", load_overrun, 0, "overrun in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", ser_out | word_mark | load_overrun, 0, "outputs after reset");
    ones = 0;
    marks = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      ones += ser_out;
      marks += word_mark;
    end
    chk("R10", ones, 0, "ones while idle");
    chk("R10", marks, 0, "markers while idle");
  endtask

  task automatic t_single;
    logic [W-1:0] w = 10'h2B6;
    int base = rx_cnt;
    int lat;
    pulse_load(w);
    wait_mark(lat);
    // lat counts negedges after the sampling edge's negedge, plus one
    chk("R9", (lat > 0 && lat + 1 <= 12) ? 1 : 0, 1, "first bit latency bound");
    for (int i = 0; i < W; i++) begin
      chk("R2", ser_out, w[W-1-i], $sformatf("serial bit %0d", i));
      if (i > 0) chk("R3", word_mark, 0, $sformatf("marker at bit %0d", i));
      @(negedge clk);
    end
    idle(12);
    chk("R5", rx_cnt - base, 1, "words received");
    if (rx_cnt > base) chk("R2", rx_w[base], w, "rebuilt word");
  endtask

  task automatic t_stream;
    logic [W-1:0] exp [12] = '{10'h0FA, 10'h305, 10'h0FA, 10'h305,
                               10'h0FA, 10'h305, 10'h3FF, 10'h000,
                               10'h200, 10'h001, 10'h155, 10'h2AA};
    int base = rx_cnt;
    int mbase = mark_cnt;
    int lat;
    pulse_load(exp[0]);
    for (int i = 1; i < 12; i++) begin
      wait_mark(lat);
      pulse_load(exp[i]);
    end
    idle(30);
    // The all-zero word still carries a marker.
    chk("R4", rx_cnt - base, 12, "stream word count");
    for (int i = 0; i < 12 && base + i < rx_cnt; i++)
      chk("R2", rx_w[base + i], exp[i], $sformatf("stream word %0d", i));
    for (int i = 1; i < 12 && mbase + i < mark_cnt; i++)
      chk("R4", mark_cyc[mbase + i] - mark_cyc[mbase + i - 1], W,
          $sformatf("marker spacing %0d", i));
  endtask

  task automatic t_overrun;
    int base = rx_cnt;
    int lat;
    idle(20);
    pulse_load(10'h1C3);
    wait_mark(lat);
    // buffer now empty: this one is taken
    word_load = 1'b1;
    word_in   = 10'h0F0;
    @(negedge clk);
    chk("R5", load_overrun, 0, "accepted strobe not flagged");
    // buffer full, no drain: this one is refused
    word_in = 10'h3C7;
    @(negedge clk);
    word_load = 1'b0;
    chk("R6", load_overrun, 1, "refused strobe flagged");
    @(negedge clk);
    chk("R6", load_overrun, 0, "overrun lasts one cycle");
    idle(40);
    chk("R6", rx_cnt - base, 2, "refused word not sent");
    if (rx_cnt >= base + 2) begin
      chk("R6", rx_w[base], 10'h1C3, "first word");
      chk("R6", rx_w[base + 1], 10'h0F0, "held word unchanged");
    end
  endtask

  task automatic t_drain_edge;
    int base = rx_cnt;
    int mbase = mark_cnt;
    int lat;
    int ovr = 0;
    idle(20);
    pulse_load(10'h2D1);
    wait_mark(lat);
    pulse_load(10'h12E);   // sampled on the edge after the marker
    idle(7);
    word_load = 1'b1;      // sampled on the draining edge
    word_in   = 10'h3A5;
    @(negedge clk);
    word_load = 1'b0;
    for (int i = 0; i < 40; i++) begin
      ovr += load_overrun;
      @(negedge clk);
    end
    chk("R5", ovr, 0, "no overrun on draining edge");
    chk("R5", rx_cnt - base, 3, "drain-edge words");
    if (rx_cnt >= base + 3) begin
      chk("R5", rx_w[base + 1], 10'h12E, "second word");
      chk("R5", rx_w[base + 2], 10'h3A5, "word loaded on drain edge");
    end
    if (mark_cnt >= mbase + 3)
      chk("R4", mark_cyc[mbase + 2] - mark_cyc[mbase + 1], W, "drain-edge spacing");
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_stream();
    t_overrun();
    t_drain_edge();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule